// File: doc/BRIEF.md
# Debounced Two-Button Display Selector

This block takes two raw push-button inputs, which bounce mechanically, and turns each one into a clean press pulse that lasts one clock cycle. The two pulses drive a clocked selection register. That register decides what a display word shows. One button selects a live data word supplied from elsewhere in the chip. The other selects a constant pattern fixed at build time. The choice stays in place until the other button is pressed.

Each raw input first passes through a two-stage synchronizer. A per-button counter then confirms the new level. The filtered level changes only after the synchronized input has disagreed with it for a full debounce period, given in clock cycles. This applies in both directions, for press and for release. Only the rising edge of the filtered level produces a pulse. A held button therefore selects once. Releases never alter the selection. No state is held outside clocked registers.

Top module: `btnsel_top`

## Requirements
- R1: A press is accepted only if the synchronized input stays high for DEB_CYCLES consecutive cycles. A high pulse on the raw input shorter than DEB_CYCLES cycles produces no tick.
- R2: A release needs DEB_CYCLES consecutive low synchronized cycles. A low dip shorter than that while the button is held produces no second tick. A genuine release followed by a new held press produces a new tick.
- R3: Assume a raw input goes high and stays high from before clock edge n. Its tick is high for exactly one cycle, from edge n+1+DEB_CYCLES to edge n+2+DEB_CYCLES.
- R4: After a tick from the live button (index 0) with no tick from the fixed button, sel_live is 1 from the next edge onward.
- R5: After a tick from the fixed button (index 1), sel_live is 0 from the next edge onward, and disp_out equals FIXED_PATTERN.
- R6: In any cycle without a tick, sel_live keeps its value. Releases and rejected bounces leave the selection unchanged.
- R7: If both ticks occur in the same cycle, the fixed pattern is selected (sel_live becomes 0).
- R8: Synchronous active-high reset clears the synchronizers, counters and filtered levels. After reset, sel_live is 0, both ticks are 0 and disp_out equals FIXED_PATTERN.
- R9: While sel_live is 1, disp_out equals live_data in the same cycle, following every change of live_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 2 | Raw buttons: bit 0 selects live data, bit 1 selects the fixed pattern |
| live_data | input | DW | Live word shown when live is selected |
| disp_out | output | DW | Selected display word |
| sel_live | output | 1 | 1 = live data shown, 0 = fixed pattern shown |
| tick_live | output | 1 | One-cycle press pulse of button 0 |
| tick_fixed | output | 1 | One-cycle press pulse of button 1 |

## Verification
The bench drives bursts shorter than the debounce period, both on press and on release, and then counts ticks. A design that skipped either debounce direction would select on bounce noise, or would fire a second tick when a held button dipped briefly. It measures the exact tick latency and width. This catches a miscounted period and a level-driven selection that re-fires while the button is held. It also presses both buttons in the same cycle, which exposes a wrong priority that leaves the live data on display. Long random bounce sequences are compared cycle by cycle against a reference model of the requirements.

// File: rtl/btnsel_pkg.sv
package btnsel_pkg;

    typedef enum logic {
        SEL_FIXED = 1'b0,
        SEL_LIVE  = 1'b1
    } sel_e;

    typedef struct packed {
        logic level;
        logic tick;
    } btn_evt_t;

    localparam int unsigned NUM_BTN   = 2;
    localparam int unsigned IDX_LIVE  = 0;
    localparam int unsigned IDX_FIXED = 1;

    // Fixed-pattern press has priority over live press.
    function automatic sel_e next_sel(input sel_e cur, input logic t_live, input logic t_fixed);
        if (t_fixed)
            return SEL_FIXED;
        else if (t_live)
            return SEL_LIVE;
        else
            return cur;
    endfunction

endpackage

// File: rtl/btnsel_sync.sv
module btnsel_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/btnsel_debounce.sv
module btnsel_debounce
    import btnsel_pkg::*;
#(
    parameter int unsigned DEB_CYCLES = 50000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_sync,
    output btn_evt_t evt
);
    localparam int unsigned CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          level_q;
    logic          tick_q;
    logic          differ;
    logic          expire;

    assign differ = (in_sync != level_q);
    assign expire = differ && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= expire && in_sync;
            if (!differ) begin
                cnt_q <= '0;
            end else if (expire) begin
                cnt_q   <= '0;
                level_q <= in_sync;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign evt.level = level_q;
    assign evt.tick  = tick_q;
endmodule

// File: rtl/btnsel_selreg.sv
module btnsel_selreg
    import btnsel_pkg::*;
#(
    parameter int unsigned     DW            = 16,
    parameter logic [DW-1:0]   FIXED_PATTERN = 16'hA5C3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          t_live,
    input  logic          t_fixed,
    input  logic [DW-1:0] live_data,
    output sel_e          sel,
    output logic [DW-1:0] disp
);
    sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= SEL_FIXED;
        else
            sel_q <= next_sel(sel_q, t_live, t_fixed);
    end

    always_comb begin
        unique case (sel_q)
            SEL_LIVE:  disp = live_data;
            default:   disp = FIXED_PATTERN;
        endcase
    end

    assign sel = sel_q;
endmodule

// File: rtl/btnsel_top.sv
module btnsel_top
    import btnsel_pkg::*;
#(
    parameter int unsigned   DW            = 16,
    parameter int unsigned   DEB_CYCLES    = 50000,
    parameter int unsigned   SYNC_STAGES   = 2,
    parameter logic [DW-1:0] FIXED_PATTERN = 16'hA5C3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    btn_raw,
    input  logic [DW-1:0] live_data,
    output logic [DW-1:0] disp_out,
    output logic          sel_live,
    output logic          tick_live,
    output logic          tick_fixed
);
    logic     [NUM_BTN-1:0] btn_sync;
    btn_evt_t [NUM_BTN-1:0] evt;
    sel_e                   sel;

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
        btnsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .d_in  (btn_raw[g]),
            .d_out (btn_sync[g])
        );
        btnsel_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk     (clk),
            .rst     (rst),
            .in_sync (btn_sync[g]),
            .evt     (evt[g])
        );
    end

    btnsel_selreg #(.DW(DW), .FIXED_PATTERN(FIXED_PATTERN)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .t_live    (evt[IDX_LIVE].tick),
        .t_fixed   (evt[IDX_FIXED].tick),
        .live_data (live_data),
        .sel       (sel),
        .disp      (disp_out)
    );

    assign sel_live   = (sel == SEL_LIVE);
    assign tick_live  = evt[IDX_LIVE].tick;
    assign tick_fixed = evt[IDX_FIXED].tick;
endmodule

// File: rtl/btnsel_chk.sv
module btnsel_chk #(
    parameter int unsigned   DW            = 16,
    parameter logic [DW-1:0] FIXED_PATTERN = 16'hA5C3
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] live_data,
    input logic [DW-1:0] disp_out,
    input logic          sel_live,
    input logic          tick_live,
    input logic          tick_fixed
);
    AST_TICK_LIVE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick_live |=> !tick_live); // R3
    AST_TICK_FIXED_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick_fixed |=> !tick_fixed); // R3
    AST_LIVE_SELECT: assert property (@(posedge clk) disable iff (rst)
        (tick_live && !tick_fixed) |=> sel_live); // R4
    AST_FIXED_SELECT: assert property (@(posedge clk) disable iff (rst)
        (tick_fixed && !tick_live) |=> (!sel_live && disp_out == FIXED_PATTERN)); // R5
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_live && !tick_fixed) |=> $stable(sel_live)); // R6
    AST_BOTH_FIXED_WINS: assert property (@(posedge clk) disable iff (rst)
        (tick_live && tick_fixed) |=> !sel_live); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!sel_live && !tick_live && !tick_fixed)); // R8
    AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        sel_live |-> (disp_out == live_data)); // R9
endmodule

bind btnsel_top btnsel_chk #(.DW(DW), .FIXED_PATTERN(FIXED_PATTERN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .live_data  (live_data),
    .disp_out   (disp_out),
    .sel_live   (sel_live),
    .tick_live  (tick_live),
    .tick_fixed (tick_fixed)
);

// File: tb/btnsel_top_bench.sv
module btnsel_top_bench;
    localparam int          PERIOD = 10;
    localparam int          DW     = 16;
    localparam int          DEB    = 6;
    localparam logic [15:0] FIXP   = 16'h3C5A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    btn_raw = 2'b00;
    logic [DW-1:0] live_data = '0;
    logic [DW-1:0] disp_out;
    logic          sel_live, tick_live, tick_fixed;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    btnsel_top #(.DW(DW), .DEB_CYCLES(DEB), .SYNC_STAGES(2), .FIXED_PATTERN(FIXP)) u_btnsel_top (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .live_data(live_data),
        .disp_out(disp_out), .sel_live(sel_live), .tick_live(tick_live), .tick_fixed(tick_fixed)
    );

    // Reference model derived from the requirements
    logic [1:0] m_s1, m_s2, m_lvl, m_tick;
    int         m_run [2];
    logic       m_sel;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_tick = '0; m_sel = 1'b0;
            m_run[0] = 0; m_run[1] = 0;
        end else begin
            if (m_tick[1]) m_sel = 1'b0;
            else if (m_tick[0]) m_sel = 1'b1;
            for (int b = 0; b < 2; b++) begin
                m_tick[b] = 1'b0;
                if (m_s2[b] == m_lvl[b]) m_run[b] = 0;
                else begin
                    m_run[b] = m_run[b] + 1;
                    if (m_run[b] == DEB) begin
                        m_lvl[b]  = m_s2[b];
                        m_tick[b] = m_s2[b];
                        m_run[b]  = 0;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = btn_raw;
        end
    end

    function automatic logic [DW-1:0] exp_disp(input logic s, input logic [DW-1:0] d);
        return s ? d : FIXP;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    bit model_on = 0;
    int n_tl = 0, n_tf = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (tick_live) n_tl++;
            if (tick_fixed) n_tf++;
            if (model_on) begin
                check("R3 tick_live vs model", 32'(tick_live), 32'(m_tick[0]));
                check("R3 tick_fixed vs model", 32'(tick_fixed), 32'(m_tick[1]));
                check("R6 sel_live vs model", 32'(sel_live), 32'(m_sel));
                check("R9 disp_out vs model", 32'(disp_out), 32'(exp_disp(m_sel, live_data)));
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; btn_raw = '0;
        cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, lat;
        void'($urandom(32'd1234));
        live_data = 16'h1111;
        do_reset();
        // R8 reset state
        check("R8 sel after reset", 32'(sel_live), 0);
        check("R8 ticks after reset", 32'({tick_live, tick_fixed}), 0);
        check("R8 disp after reset", 32'(disp_out), 32'(FIXP));

        // R1 short press rejected
        base = n_tl;
        btn_raw[0] = 1'b1; cyc(DEB - 1); btn_raw[0] = 1'b0;
        cyc(3 * DEB);
        check("R1 short press no tick", 32'(n_tl - base), 0);
        check("R1 sel unchanged", 32'(sel_live), 0);

        // R3 latency and width
        btn_raw[0] = 1'b1; lat = 0;
        do begin cyc(1); lat++; end while (!tick_live && lat < 50);
        check("R3 tick latency edges", 32'(lat), 32'(DEB + 2));
        cyc(1);
        check("R3 tick width one cycle", 32'(tick_live), 0);
        // R4 selected live
        check("R4 sel_live after live tick", 32'(sel_live), 1);
        live_data = 16'hBEEF; #1;
        check("R9 disp follows live change", 32'(disp_out), 32'h0000BEEF);
        cyc(1);

        // R2 short release dip while held
        base = n_tl;
        btn_raw[0] = 1'b0; cyc(DEB - 1); btn_raw[0] = 1'b1;
        cyc(3 * DEB);
        check("R2 dip no retick", 32'(n_tl - base), 0);
        // R6 genuine release keeps selection
        btn_raw[0] = 1'b0; cyc(3 * DEB);
        check("R6 release keeps live", 32'(sel_live), 1);
        btn_raw[0] = 1'b1; cyc(3 * DEB);
        check("R2 repress gives tick", 32'(n_tl - base), 1);
        btn_raw[0] = 1'b0; cyc(3 * DEB);

        // R5 fixed selection
        btn_raw[1] = 1'b1; cyc(DEB + 4);
        check("R5 sel fixed", 32'(sel_live), 0);
        check("R5 disp fixed", 32'(disp_out), 32'(FIXP));
        btn_raw[1] = 1'b0; cyc(3 * DEB);
        check("R6 release keeps fixed", 32'(sel_live), 0);

        // R7 both pressed together from live state
        btn_raw[0] = 1'b1; cyc(DEB + 4); btn_raw[0] = 1'b0; cyc(3 * DEB);
        check("R4 live before simultaneous", 32'(sel_live), 1);
        base = n_tf;
        btn_raw = 2'b11; cyc(DEB + 4);
        check("R7 fixed tick seen", 32'(n_tf - base), 1);
        check("R7 fixed wins", 32'(sel_live), 0);
        btn_raw = 2'b00; cyc(3 * DEB);

        // Random bouncing compared against the model
        do_reset();
        model_on = 1;
        for (int k = 0; k < 600; k++) begin
            int hold;
            btn_raw   = 2'($urandom_range(0, 3));
            hold      = $urandom_range(1, 2 * DEB + 3);
            for (int j = 0; j < hold; j++) begin
                live_data = 16'($urandom);
                cyc(1);
            end
        end
        // R8 reset mid-operation
        rst = 1'b1; cyc(2);
        check("R8 reset mid-run sel", 32'(sel_live), 0);
        model_on = 0;
        rst = 1'b0; btn_raw = '0; cyc(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule